// File: doc/BRIEF.md
# Receive Byte Queue with Break Insertion

This block sits between a serial receiver and the register unit of an asynchronous serial port. It holds up to four received bytes in arrival order. Bytes come in over a valid/ready handshake, and ready is offered only while the receiver is enabled and the queue has room. The host takes the oldest byte with a data-read strobe. The data is presented in the same cycle as the strobe, and the entry is retired at the next clock edge.

The block keeps two status flags for the register unit: "data available" and "queue full". A line-break event from the receiver is always accepted. It stores a zero byte and raises a sticky break-change flag. When the queue is already full, the zero byte takes the place of the newest entry instead of being dropped. A flush input, driven by the receiver-reset command, empties the queue. An interrupt line combines the receive condition, which can be taken from either flag, and the break flag, each under its own mask.

Top module: `rx_break_fifo`

## Requirements
- R1: The queue holds exactly four bytes. `rd_data` always shows the oldest stored byte, and each `host_rd` retires that byte at the next edge.
- R2: While the queue is empty, `rd_data` is 0x00 and a `host_rd` changes no state.
- R3: `in_ready` is 1 only when `rx_en` is 1, the queue holds fewer than four bytes, and neither `brk_event` nor `flush` is asserted. A byte offered while `in_ready` is 0 is not stored.
- R4: `stat_rdy` is 1 after any accepted byte or break. It falls only when the count reaches zero.
- R5: `stat_full` rises when the count reaches four. Any pop that is not joined by a break clears it.
- R6: `brk_event` stores a 0x00 byte and sets `brk_flag`. On a full queue, the zero replaces the newest entry and the count stays at four.
- R7: `flush` empties the queue and clears `stat_rdy` and `stat_full`. It overrides a push, a pop and the break byte in the same cycle.
- R8: A pop and an accepted push in the same cycle leave the count unchanged and keep the arrival order.
- R9: `irq` = (`irq_mask[0]` AND (`irq_src_full` ? `stat_full` : `stat_rdy`)) OR (`irq_mask[1]` AND `brk_flag`). It follows the flags in the same cycle in which they change.
- R10: `brk_clear` clears `brk_flag`. A `brk_event` in the same cycle wins, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable |
| in_valid | input | 1 | Incoming byte valid |
| in_data | input | 8 | Incoming byte |
| in_ready | output | 1 | Queue accepts a byte this cycle |
| brk_event | input | 1 | Line break detected |
| brk_clear | input | 1 | Clear the break-change flag |
| flush | input | 1 | Receiver reset: empty the queue |
| host_rd | input | 1 | Host reads and retires the oldest byte |
| rd_data | output | 8 | Oldest byte, 0x00 when empty |
| stat_rdy | output | 1 | At least one byte stored |
| stat_full | output | 1 | Four bytes stored |
| brk_flag | output | 1 | Sticky break-change flag |
| irq_src_full | input | 1 | Receive interrupt taken from full (1) or ready (0) |
| irq_mask | input | 2 | Bit 0 receive interrupt enable, bit 1 break interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
`rd_data`, `in_ready` and `irq` are combinational outputs and are due in the same cycle as their inputs. `stat_rdy`, `stat_full` and `brk_flag` change one edge after the push, pop, break, clear or flush that moves them. The bench drives inputs on the falling edge and compares every output one nanosecond later against a queue-based model. It updates that model only after the following rising edge, so each registered result is compared in the first cycle it is due.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   // Modular index wrap for a ring of arbitrary depth; argument stays below 2*depth.
   function automatic int wrap_idx(input int v, input int depth);
      return (v >= depth) ? v - depth : v;
   endfunction

   typedef enum logic {
      RXQ_SRC_READY = 1'b0,
      RXQ_SRC_FULL  = 1'b1
   } rxq_src_e;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
   parameter int DEPTH = 4,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          pop_req,
   input  logic          push_req,
   input  logic          brk,
   output logic [CW-1:0] count,
   output logic [PW-1:0] head,
   output logic          wr_en,
   output logic [PW-1:0] wr_idx
);
   import rxq_pkg::*;

   logic [CW-1:0] cnt_q, cnt_d;
   logic [PW-1:0] head_q, head_d;

   always_comb begin
      int c;
      int h;
      int w;
      c = int'(cnt_q);
      h = int'(head_q);
      w = 0;
      wr_en = 1'b0;
      // pop first, so a same-cycle push lands behind the remaining bytes
      if (pop_req && c != 0) begin
         c = c - 1;
         h = wrap_idx(h + 1, DEPTH);
      end
      if (brk) begin
         wr_en = 1'b1;
         if (c == DEPTH) begin
            w = wrap_idx(h + DEPTH - 1, DEPTH);   // replace newest
         end else begin
            w = wrap_idx(h + c, DEPTH);
            c = c + 1;
         end
      end else if (push_req) begin
         wr_en = 1'b1;
         w = wrap_idx(h + c, DEPTH);
         c = c + 1;
      end
      if (flush) begin
         wr_en = 1'b0;
         c = 0;
         h = 0;
      end
      cnt_d  = CW'(c);
      head_d = PW'(h);
      wr_idx = PW'(w);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         head_q <= '0;
      end else begin
         cnt_q  <= cnt_d;
         head_q <= head_d;
      end
   end

   assign count = cnt_q;
   assign head  = head_q;
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DATA_W        = 8,
   parameter int DEPTH         = 4,
   parameter bit CLEAR_STORAGE = 1'b1,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PW-1:0]     wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [PW-1:0]     rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] slot [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      if (CLEAR_STORAGE) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot[i] <= '0;
            else if (wr_en && wr_idx == PW'(i)) slot[i] <= wr_data;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (wr_en && wr_idx == PW'(i)) slot[i] <= wr_data;
         end
      end
   end

   assign rd_data = slot[rd_idx];
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       brk_set,
   input  logic       brk_clr,
   input  logic       stat_rdy,
   input  logic       stat_full,
   input  logic       src_sel,
   input  logic [1:0] mask,
   output logic       brk_flag,
   output logic       irq
);
   import rxq_pkg::*;

   logic flag_q;
   logic rx_cond;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (brk_set)  flag_q <= 1'b1;
      else if (brk_clr)  flag_q <= 1'b0;
   end

   always_comb begin
      unique case (rxq_src_e'(src_sel))
         RXQ_SRC_FULL:  rx_cond = stat_full;
         default:       rx_cond = stat_rdy;
      endcase
   end

   assign brk_flag = flag_q;
   assign irq      = (mask[0] & rx_cond) | (mask[1] & flag_q);
endmodule

// File: rtl/rx_break_fifo.sv
module rx_break_fifo #(
   parameter int DATA_W        = 8,
   parameter int DEPTH         = 4,
   parameter bit CLEAR_STORAGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   input  logic              brk_event,
   input  logic              brk_clear,
   input  logic              flush,
   input  logic              host_rd,
   output logic [DATA_W-1:0] rd_data,
   output logic              stat_rdy,
   output logic              stat_full,
   output logic              brk_flag,
   input  logic              irq_src_full,
   input  logic [1:0]        irq_mask,
   output logic              irq
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("rx_break_fifo: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("rx_break_fifo: DATA_W must be positive");
   end

   logic [CW-1:0]     count;
   logic [PW-1:0]     head;
   logic              wr_en;
   logic [PW-1:0]     wr_idx;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] oldest;
   logic              push_ok;

   assign stat_rdy  = (count != '0);
   assign stat_full = (count == CW'(DEPTH));
   assign in_ready  = rx_en & ~stat_full & ~brk_event & ~flush;
   assign push_ok   = in_valid & in_ready;
   assign wr_data   = brk_event ? '0 : in_data;
   assign rd_data   = stat_rdy ? oldest : '0;

   rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .pop_req  (host_rd),
      .push_req (push_ok),
      .brk      (brk_event),
      .count    (count),
      .head     (head),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx)
   );

   rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CLEAR_STORAGE(CLEAR_STORAGE)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (head),
      .rd_data (oldest)
   );

   rxq_irq u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .brk_set   (brk_event),
      .brk_clr   (brk_clear),
      .stat_rdy  (stat_rdy),
      .stat_full (stat_full),
      .src_sel   (irq_src_full),
      .mask      (irq_mask),
      .brk_flag  (brk_flag),
      .irq       (irq)
   );
endmodule

// File: rtl/rx_break_fifo_chk.sv
module rx_break_fifo_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       in_ready,
   input logic       brk_event,
   input logic       brk_clear,
   input logic       flush,
   input logic       host_rd,
   input logic       stat_rdy,
   input logic       stat_full,
   input logic       brk_flag,
   input logic [1:0] irq_mask,
   input logic       irq
);
   p_full_blocks_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stat_full |-> !in_ready);

   p_empty_read_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !stat_rdy && !in_valid && !brk_event) |=> !stat_rdy);

   p_push_sets_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> stat_rdy);

   p_pop_clears_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && stat_full && !brk_event) |=> !stat_full);

   p_break_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      brk_event |=> brk_flag);

   p_break_on_full_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_event && stat_full && !flush) |=> stat_full);

   p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!stat_rdy && !stat_full));

   p_clear_drops_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_clear && !brk_event) |=> !brk_flag);

   p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_mask == 2'b00) |-> !irq);
endmodule

bind rx_break_fifo rx_break_fifo_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .brk_event (brk_event),
   .brk_clear (brk_clear),
   .flush     (flush),
   .host_rd   (host_rd),
   .stat_rdy  (stat_rdy),
   .stat_full (stat_full),
   .brk_flag  (brk_flag),
   .irq_mask  (irq_mask),
   .irq       (irq)
);

// File: tb/tb_rx_break_fifo.sv
`timescale 1ns/1ps
module tb_rx_break_fifo;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_en = 1'b0, in_valid = 1'b0, brk_event = 1'b0, brk_clear = 1'b0;
   logic       flush = 1'b0, host_rd = 1'b0, irq_src_full = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic [1:0] irq_mask = 2'b00;
   logic       in_ready, stat_rdy, stat_full, brk_flag, irq;
   logic [7:0] rd_data;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // reference model
   logic [7:0] q[$];
   bit m_brk = 1'b0;

   always #2.5 clk = ~clk;

   rx_break_fifo dut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .brk_event(brk_event), .brk_clear(brk_clear), .flush(flush),
      .host_rd(host_rd), .rd_data(rd_data), .stat_rdy(stat_rdy), .stat_full(stat_full),
      .brk_flag(brk_flag), .irq_src_full(irq_src_full), .irq_mask(irq_mask), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit exp_ready();
      return rx_en && q.size() < 4 && !brk_event && !flush;
   endfunction

   task automatic compare_all();
      bit rx_c;
      rx_c = irq_src_full ? (q.size() == 4) : (q.size() != 0);
      chk("R1/R2 rd_data", rd_data, (q.size() != 0) ? q[0] : 8'h00);
      chk("R3 in_ready", in_ready, exp_ready());
      chk("R4 stat_rdy", stat_rdy, q.size() != 0);
      chk("R5 stat_full", stat_full, q.size() == 4);
      chk("R6/R10 brk_flag", brk_flag, m_brk);
      chk("R9 irq", irq, (irq_mask[0] && rx_c) || (irq_mask[1] && m_brk));
   endtask

   // one cycle: drive at falling edge, compare, apply edge, advance the model
   task automatic cyc(input bit en, input bit v, input logic [7:0] d, input bit rd,
                      input bit brk, input bit clr, input bit fl);
      bit acc;
      @(negedge clk);
      rx_en = en; in_valid = v; in_data = d; host_rd = rd;
      brk_event = brk; brk_clear = clr; flush = fl;
      #1;
      compare_all();
      acc = v && exp_ready();
      @(posedge clk);
      if (fl) q.delete();
      else begin
         if (rd && q.size() != 0) void'(q.pop_front());
         if (brk) begin
            if (q.size() == 4) q[3] = 8'h00;
            else q.push_back(8'h00);
         end else if (acc) q.push_back(d);
      end
      if (brk) m_brk = 1'b1;
      else if (clr) m_brk = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 compare_all();              // reset state (R4, R5, R9)
      rst_n = 1'b1;
      irq_mask = 2'b11;
      // R3: disabled receiver refuses bytes
      cyc(0, 1, 8'h11, 0, 0, 0, 0);
      // R2: read when empty
      cyc(1, 0, 8'h00, 1, 0, 0, 0);
      // R1/R4/R5: fill to four, then an extra offer while full
      cyc(1, 1, 8'hA1, 0, 0, 0, 0);
      cyc(1, 1, 8'hA2, 0, 0, 0, 0);
      cyc(1, 1, 8'hA3, 0, 0, 0, 0);
      cyc(1, 1, 8'hA4, 0, 0, 0, 0);
      cyc(1, 1, 8'hA5, 0, 0, 0, 0);
      irq_src_full = 1'b1;            // R9 full-sourced
      cyc(1, 0, 8'h00, 0, 0, 0, 0);
      // R6: break on full replaces newest
      cyc(1, 0, 8'h00, 0, 1, 0, 0);
      // R10: clear together with break, then clear alone
      cyc(1, 0, 8'h00, 0, 1, 1, 0);
      cyc(1, 0, 8'h00, 0, 0, 1, 0);
      // R5: pop from full
      cyc(1, 0, 8'h00, 1, 0, 0, 0);
      // R8: push and pop together
      cyc(1, 1, 8'hB1, 1, 0, 0, 0);
      cyc(1, 1, 8'hB2, 1, 0, 0, 0);
      // R1 drain in order
      for (int i = 0; i < 5; i++) cyc(1, 0, 8'h00, 1, 0, 0, 0);
      // R7: flush beats push and break
      cyc(1, 1, 8'hC1, 0, 0, 0, 0);
      cyc(1, 1, 8'hC2, 1, 1, 0, 1);
      cyc(1, 0, 8'h00, 0, 0, 0, 0);
      // R6 on empty, then R9 under each mask
      cyc(1, 0, 8'h00, 0, 1, 0, 0);
      irq_src_full = 1'b0;
      for (int m = 0; m < 4; m++) begin
         irq_mask = 2'(m);
         cyc(1, 0, 8'h00, 0, 0, 0, 0);
      end
      // mixed traffic
      for (int i = 0; i < 600; i++) begin
         int r;
         r = $urandom;
         irq_mask = 2'(r >> 20);
         irq_src_full = r[22];
         cyc((r % 8) != 0, r[3], 8'(r >> 8), r[4] & r[5],
             (r % 23) == 0, (r % 17) == 0, (r % 41) == 0);
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule